// File: doc/BRIEF.md
# Serial Character Transmitter with Break and Idle Generation

This block turns parallel characters into an asynchronous serial stream on a single line. A character is a space start bit, eight or nine data bits with the least significant bit first, an optional parity bit and a mark stop bit. The block can also send unframed filler characters. An idle character holds the line at mark. A break character holds the line at space. A bit-rate tick from an external baud generator paces the line, and each bit lasts a fixed number of ticks.

The enable input controls the line. When enable rises from the off state, the block sends one idle character as a preamble before anything else. When enable falls, the character already on the line is allowed to finish. If enable falls and then rises again while a character is on the line, one idle character is queued behind it. A send-break request produces break characters back to back for as long as it is held. Once the request is released, the last break is always followed by at least one mark bit. An extended break length is available for bus protocols that need a longer break. A polarity select inverts every level on the line.

Top module: `uart_brk_tx`

## Requirements
- R1: While reset is held, and afterwards while enable is low, txd stays at the mark level and tx_ready stays low.
- R2: An accepted data character starts on the line in the cycle after the accepting clock edge. Its bits, in order, are: start (0), then data bits tx_data[0] upward (8 in 8-bit mode, where tx_data[8] is ignored; 9 in 9-bit mode), then, when par_en is 1, a parity bit, then stop (1). The parity bit is the XOR of the data bits, inverted when par_odd is 1. The mode inputs are sampled when the character is accepted.
- R3: tx_ready is high only when enable is high, no break is requested and no idle is queued. Within those limits it is high while the line is waiting, and also in the last cycle of a character, so that data characters can follow each other with no gap. A character is accepted when tx_valid and tx_ready are both high at a clock edge.
- R4: When enable rises from the off state, one idle (mark) character is sent first. Its length is 10 bits, plus 1 in 9-bit mode, plus 1 when parity is on. tx_ready first rises in the final cycle of that preamble.
- R5: A break character is space for its whole length, with no start, parity or stop framing. Its length is 10 bits in 8-bit mode and 11 bits in 9-bit mode, with 3 more bits when long_brk is 1.
- R6: If brk_req is still high when a break ends, another break follows with no gap.
- R7: When a break ends and brk_req is low, the line is held at mark for exactly one bit time before any other character starts.
- R8: If enable goes low during a character, that character completes and the line then stays at mark. After that, tx_ready stays low and both tx_valid and brk_req are ignored until enable rises again, and that rising edge starts a new preamble.
- R9: If enable falls and rises again during a character, one idle character of the data-character length follows the current character before data is accepted.
- R10: A break followed by a queued idle keeps its full length. It is followed by the one mark bit and then the idle character.
- R11: When inv_out is 1, every level on txd is inverted, including idle, mark, stop and break levels.
- R12: Each bit lasts OVS tick pulses. Cycles without a tick do not advance the line.
- R13: A pending break request takes priority over pending data. The data is accepted only after the break and its trailing mark have been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Bit-rate tick; OVS ticks make one bit |
| tx_en | input | 1 | Transmitter enable |
| brk_req | input | 1 | Send-break request, held high for repeated breaks |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 data bits |
| long_brk | input | 1 | Adds 3 bits to the break length |
| par_en | input | 1 | Appends a parity bit to data characters |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| inv_out | input | 1 | Inverts all levels on txd |
| tx_data | input | 9 | Character to send |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | The block accepts tx_data at this clock edge |
| txd | output | 1 | Serial output line |

## Verification
Every result on the line lands a fixed number of cycles after the edge that caused it. A data character or break starts in the cycle right after the deciding edge, and bit k then occupies cycles 16k+1 through 16k+16 when the tick is high every cycle. tx_ready can be seen at a falling edge in the same cycle as the clock edge that decides. The bench therefore samples txd at every falling edge of each expected bit, which checks both the level and the exact bit boundaries. It also counts the falling edges until tx_ready rises, which measures preamble and queued-idle lengths as exact multiples of 16 cycles. In the slow-tick run, the bench aligns acceptance to a tick so that every bit spans exactly 32 cycles.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;

  localparam int DW = 9;
  localparam int FW = DW + 5;
  localparam int LW = $clog2(FW + 1);

  typedef enum logic [2:0] {
    K_OFF, K_WAIT, K_PRE, K_IDLE, K_DATA, K_BRK, K_MARK
  } kind_e;

  // framed data or idle character length in bits
  function automatic logic [LW-1:0] char_len(input logic nine, input logic par);
    return LW'(DW + 1 + int'(nine) + int'(par));
  endfunction

  // break length: framed length without parity, optionally extended by 3
  function automatic logic [LW-1:0] brk_len(input logic nine, input logic lng);
    return LW'(DW + 1 + int'(nine) + (lng ? 3 : 0));
  endfunction

  // shift word, bit 0 goes out first; unused upper bits stay mark
  function automatic logic [FW-1:0] build_frame(input logic [DW-1:0] d,
                                                input logic nine,
                                                input logic pen,
                                                input logic podd);
    logic [FW-1:0] f;
    logic p;
    int pos;
    f = '1;
    f[0] = 1'b0;
    p = podd;
    for (int i = 0; i < DW; i++) begin
      if (i < DW - 1 || nine) begin
        f[i+1] = d[i];
        p = p ^ d[i];
      end
    end
    pos = nine ? DW + 1 : DW;
    if (pen) f[pos] = p;
    return f;
  endfunction

endpackage

// File: rtl/uart_bit_timer.sv
module uart_bit_timer #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic tick,
  output logic bit_end
);
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [CW-1:0] cnt;

  assign bit_end = !hold && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (hold)    cnt <= '0;
    else if (tick)    cnt <= bit_end ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/uart_frame_shifter.sv
module uart_frame_shifter import uart_brk_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] load_word,
  input  logic [LW-1:0] load_len,
  input  logic          bit_end,
  output logic          line,
  output logic          char_done
);
  logic [FW-1:0] sh;
  logic [LW-1:0] left;

  assign char_done = bit_end && (left == LW'(1));
  assign line      = (left != '0) ? sh[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '1;
      left <= '0;
    end else if (load) begin
      sh   <= load_word;
      left <= load_len;
    end else if (bit_end && left != '0) begin
      sh   <= {1'b1, sh[FW-1:1]};
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl import uart_brk_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          brk_req,
  input  logic          nine_bit,
  input  logic          long_brk,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  input  logic          char_done,
  output logic          tx_ready,
  output logic          ld,
  output logic [FW-1:0] ld_word,
  output logic [LW-1:0] ld_len,
  output logic          tmr_hold,
  output logic          is_off,
  output logic          brk_start,
  output logic          mark_start
);
  kind_e st, nxt;
  logic  gap_q, idle_q;
  logic  at_bound, busy_k;

  assign busy_k   = (st != K_OFF) && (st != K_WAIT);
  assign at_bound = char_done || (st == K_WAIT);
  assign tmr_hold = (st == K_OFF) || (st == K_WAIT);

  always_comb begin
    nxt      = st;
    ld       = 1'b0;
    ld_word  = '1;
    ld_len   = '0;
    tx_ready = 1'b0;
    if (st == K_OFF) begin
      if (tx_en) begin
        nxt    = K_PRE;
        ld     = 1'b1;
        ld_len = char_len(nine_bit, par_en);
      end
    end else if (at_bound) begin
      if (st == K_BRK) begin
        ld = 1'b1;
        if (brk_req && tx_en) begin
          nxt     = K_BRK;
          ld_word = '0;
          ld_len  = brk_len(nine_bit, long_brk);
        end else begin
          nxt    = K_MARK;
          ld_len = LW'(1);
        end
      end else if (!tx_en) begin
        nxt = K_OFF;
      end else if (idle_q) begin
        nxt    = K_IDLE;
        ld     = 1'b1;
        ld_len = char_len(nine_bit, par_en);
      end else if (brk_req) begin
        nxt     = K_BRK;
        ld      = 1'b1;
        ld_word = '0;
        ld_len  = brk_len(nine_bit, long_brk);
      end else begin
        tx_ready = 1'b1;
        if (tx_valid) begin
          nxt     = K_DATA;
          ld      = 1'b1;
          ld_word = build_frame(tx_data, nine_bit, par_en, par_odd);
          ld_len  = char_len(nine_bit, par_en);
        end else begin
          nxt = K_WAIT;
        end
      end
    end
  end

  assign is_off     = (st == K_OFF);
  assign brk_start  = ld && (nxt == K_BRK);
  assign mark_start = ld && (nxt == K_MARK);

  always_ff @(posedge clk) begin
    if (!rst_n) st <= K_OFF;
    else        st <= nxt;
  end

  // enable toggle tracking; a break boundary keeps a queued idle pending
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q  <= 1'b0;
      idle_q <= 1'b0;
    end else if ((at_bound && st != K_BRK) || st == K_OFF) begin
      gap_q  <= 1'b0;
      idle_q <= 1'b0;
    end else if (busy_k) begin
      if (!tx_en)     gap_q  <= 1'b1;
      else if (gap_q) idle_q <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx import uart_brk_pkg::*; #(
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          tx_en,
  input  logic          brk_req,
  input  logic          nine_bit,
  input  logic          long_brk,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          inv_out,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic          txd
);
  logic          bit_end, char_done, tmr_hold, ld, line;
  logic [FW-1:0] ld_word;
  logic [LW-1:0] ld_len;
  logic          is_off, brk_start, mark_start;

  uart_bit_timer #(.OVS(OVS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .hold(tmr_hold), .tick(tick), .bit_end(bit_end)
  );

  uart_frame_shifter u_shf (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_word(ld_word), .load_len(ld_len),
    .bit_end(bit_end), .line(line), .char_done(char_done)
  );

  uart_tx_ctrl u_ctl (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .brk_req(brk_req),
    .nine_bit(nine_bit), .long_brk(long_brk), .par_en(par_en), .par_odd(par_odd),
    .tx_data(tx_data), .tx_valid(tx_valid), .char_done(char_done),
    .tx_ready(tx_ready), .ld(ld), .ld_word(ld_word), .ld_len(ld_len),
    .tmr_hold(tmr_hold), .is_off(is_off), .brk_start(brk_start),
    .mark_start(mark_start)
  );

  assign txd = line ^ inv_out;
endmodule

// File: rtl/uart_brk_tx_chk.sv
module uart_brk_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic tx_en,
  input logic brk_req,
  input logic inv_out,
  input logic tx_valid,
  input logic tx_ready,
  input logic txd,
  input logic bit_end,
  input logic char_done,
  input logic is_off,
  input logic brk_start,
  input logic mark_start
);
  a_r3_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (tx_en && !brk_req));

  a_r2_start_space: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (txd == inv_out));

  a_r5_break_space: assert property (@(posedge clk) disable iff (!rst_n)
    brk_start |=> (txd == inv_out));

  a_r7_mark_level: assert property (@(posedge clk) disable iff (!rst_n)
    mark_start |=> (txd == !inv_out));

  a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    is_off |-> (txd == !inv_out && !tx_ready));

  a_r12_tick_gate: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |-> tick);

  a_r12_done_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |-> bit_end);
endmodule

bind uart_brk_tx uart_brk_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(tx_en), .brk_req(brk_req),
  .inv_out(inv_out), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
  .bit_end(bit_end), .char_done(char_done), .is_off(is_off),
  .brk_start(brk_start), .mark_start(mark_start)
);

// File: tb/tb_uart_brk_tx.sv
`timescale 1ns/1ps
module tb_uart_brk_tx;
  logic clk = 1'b0;
  logic rst_n, tick, tx_en, brk_req, nine, lng, pen, podd, inv, tx_valid, tx_ready, txd;
  logic [8:0] tx_data;
  logic slow = 1'b0;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  uart_brk_tx #(.OVS(16)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(tx_en), .brk_req(brk_req),
    .nine_bit(nine), .long_brk(lng), .par_en(pen), .par_odd(podd), .inv_out(inv),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd)
  );

  initial begin
    tick = 1'b1;
    forever begin
      @(negedge clk);
      tick = slow ? ~tick : 1'b1;
    end
  end

  function automatic int flen();
    return 10 + int'(nine) + int'(pen);
  endfunction

  function automatic int blen();
    return 10 + int'(nine) + (lng ? 3 : 0);
  endfunction

  function automatic logic exp_bit(input logic [8:0] d, input int k);
    int n = nine ? 9 : 8;
    int ones;
    if (k == 0) return 1'b0;
    if (k <= n) return d[k-1];
    if (k == n + 1 && pen) begin
      ones = $countones(nine ? d : {1'b0, d[7:0]});
      return logic'(ones % 2) ^ podd;
    end
    return 1'b1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // sample every falling edge of nbits bit times at level lvl (before inversion)
  task automatic expect_seg(input logic lvl, input int nbits, input string req);
    for (int b = 0; b < nbits; b++) begin
      int bad = 0;
      logic seen = 1'b0;
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        if (txd !== (lvl ^ inv)) begin bad++; seen = txd; end
      end
      chk(bad == 0, req, int'(seen), int'(lvl ^ inv));
    end
  endtask

  // offer one character; exp_w is the expected falling-edge wait for ready (-1: skip)
  task automatic send(input logic [8:0] d, input int exp_w, input string req);
    int w = 0, mbad = 0, spb;
    spb = slow ? 32 : 16;
    tx_data = d;
    if (!slow) tx_valid = 1'b1;
    #1;
    while (!(tx_ready && (!slow || tick)) && w < 5000) begin
      @(negedge clk); #1;
      w++;
      if (txd !== !inv) mbad++;
    end
    tx_valid = 1'b1;
    if (exp_w >= 0) chk(w == exp_w, req, w, exp_w);
    if (w > 0) chk(mbad == 0, req, mbad, 0);
    for (int k = 0; k < flen(); k++) begin
      int bad = 0;
      for (int c = 0; c < spb; c++) begin
        @(negedge clk);
        if (k == 0 && c == 0) tx_valid = 1'b0;
        if (txd !== (exp_bit(d, k) ^ inv)) bad++;
      end
      chk(bad == 0, req, bad, 0);
    end
  endtask

  task automatic run_all();
    // R1: reset and disabled state
    rst_n = 1'b0; tx_en = 0; brk_req = 0; nine = 0; lng = 0; pen = 0; podd = 0;
    inv = 0; tx_valid = 0; tx_data = '0;
    repeat (3) @(negedge clk);
    chk(txd === 1'b1, "R1", int'(txd), 1);
    chk(tx_ready === 1'b0, "R1", int'(tx_ready), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(txd === 1'b1 && tx_ready === 1'b0, "R1", int'(txd), 1);

    // R4: preamble then first character
    tx_en = 1'b1;
    send(9'h100, 160, "R4");

    // R2/R3: exhaustive 8-bit sweep back to back, bit 8 ignored
    for (int i = 1; i < 256; i++) send({i[0], i[7:0]}, 0, "R2_R3");

    // R2: 9-bit and parity sweep
    for (int c = 0; c < 8; c++) begin
      nine = c[2]; pen = c[1]; podd = c[0];
      for (int i = 0; i < 12; i++) send(9'((i * 37 + 5 + c * 91) & 9'h1FF), 0, "R2");
    end

    // R12: slow tick, 32 cycles per bit
    slow = 1'b1;
    send(9'h1A5, -1, "R12");
    slow = 1'b0;
    nine = 1'b1; pen = 1'b0;
    send(9'h0C3, -1, "R12");
    nine = 1'b0;

    // R5/R6/R13/R7: held break with pending data
    brk_req = 1'b1; tx_data = 9'h03C; tx_valid = 1'b1;
    #1;
    chk(tx_ready === 1'b0, "R13", int'(tx_ready), 0);
    expect_seg(1'b0, 10, "R5");
    expect_seg(1'b0, 5, "R6");
    brk_req = 1'b0;
    expect_seg(1'b0, 5, "R6");
    expect_seg(1'b1, 1, "R7");
    send(9'h03C, 0, "R13");

    // R5: long breaks in both modes
    lng = 1'b1;
    for (int m = 0; m < 2; m++) begin
      nine = m[0];
      brk_req = 1'b1;
      expect_seg(1'b0, 1, "R5");
      brk_req = 1'b0;
      expect_seg(1'b0, blen() - 1, "R5");
      expect_seg(1'b1, 1, "R7");
    end
    lng = 1'b0; nine = 1'b0;
    send(9'h055, 0, "R7");

    // R11: inverted line
    inv = 1'b1;
    #1;
    chk(txd === 1'b0, "R11", int'(txd), 0);
    send(9'h0B2, 0, "R11");
    brk_req = 1'b1;
    expect_seg(1'b0, 1, "R11");
    brk_req = 1'b0;
    expect_seg(1'b0, 9, "R11");
    expect_seg(1'b1, 1, "R11");
    @(negedge clk);
    inv = 1'b0;

    // R9: enable toggle during a character queues one idle
    fork
      send(9'h05A, 0, "R9");
      begin
        repeat (50) @(negedge clk);
        tx_en = 1'b0;
        repeat (4) @(negedge clk);
        tx_en = 1'b1;
      end
    join
    send(9'h0A5, 160, "R9");

    // R8: enable drop mid-character, then ignored inputs
    fork
      send(9'h081, 0, "R8");
      begin
        repeat (30) @(negedge clk);
        tx_en = 1'b0;
      end
    join
    begin
      int bad = 0;
      tx_valid = 1'b1; brk_req = 1'b1;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (txd !== 1'b1 || tx_ready !== 1'b0) bad++;
      end
      chk(bad == 0, "R8", bad, 0);
    end
    brk_req = 1'b0; tx_valid = 1'b0;
    tx_en = 1'b1;
    send(9'h018, 160, "R4");

    // R10: break followed by queued idle keeps full length
    brk_req = 1'b1;
    fork
      expect_seg(1'b0, 10, "R10");
      begin
        repeat (20) @(negedge clk);
        tx_en = 1'b0;
        repeat (3) @(negedge clk);
        tx_en = 1'b1;
        brk_req = 1'b0;
      end
    join
    expect_seg(1'b1, 1, "R10");
    send(9'h0E7, 160, "R10");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule